// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block tracks one reservation for atomic read-modify-write sequences. A reserving load records that a reservation exists, together with the effective address and the access size. A later conditional store checks the request against that record. It reports whether the store may be performed, and gives a 4-bit condition nibble that combines a success flag with a summary-overflow bit supplied by the caller.

Every conditional store clears the reservation, whether it succeeds or fails. A new reserving load replaces any reservation already held. An external invalidate input, for example a snoop hit or a context switch, drops the reservation. The memory array and coherence snooping lie outside the block. Only the invalidate line connects the block to them.

Request encoding on `req_op`: 2'b01 is a reserving load, 2'b10 is a conditional store, and 2'b00 and 2'b11 are no operation. Size encoding on `req_size` and `resv_size`: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes.

Top module: `lrsc_monitor`

## Requirements
- R1: While and after a synchronous reset, `resv_valid`, `store_ok`, `status_done` and `status` are all 0.
- R2: A reserving load (op 2'b01) without invalidate sets `resv_valid` and records `req_addr` in `resv_addr` and `req_size` in `resv_size` (0=1B, 1=2B, 2=4B, 3=8B). These outputs are visible after the clock edge that accepts the request.
- R3: A reserving load that arrives while a reservation is held overwrites the recorded address and size.
- R4: A conditional store (op 2'b10) succeeds (`store_ok`=1) only when a reservation is valid, the recorded address equals `req_addr`, and the recorded size code equals `req_size`. A match on one of these alone fails.
- R5: On success `status` is 4'b0010 OR {3'b000, sum_ovf}. On failure it is {3'b000, sum_ovf}. Bits 3:2 are always 0.
- R6: After every conditional store, whether it succeeded or failed, `resv_valid` is 0.
- R7: `inval` clears the reservation. When `inval` is high in the same cycle as a reserving load, no reservation is made. When it is high in the same cycle as a conditional store, that store fails.
- R8: `status_done`, `store_ok` and `status` are registered. `status_done` is high for exactly the one cycle after the edge that accepted a conditional store. While `status_done` is low, `store_ok` and `status` are 0.
- R9: Ops 2'b00 and 2'b11 leave the reservation state unchanged and raise no `status_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2 | Request type: 01 reserve, 10 conditional store, 00/11 none |
| req_size | input | 2 | Access size code (0=1B, 1=2B, 2=4B, 3=8B) |
| req_addr | input | AW | Effective address of the request |
| sum_ovf | input | 1 | Summary-overflow bit merged into the status nibble |
| inval | input | 1 | Drops the reservation |
| store_ok | output | 1 | Conditional store may be performed |
| status_done | output | 1 | One-cycle strobe: result of a conditional store is valid |
| status | output | 4 | Condition nibble of the conditional store |
| resv_valid | output | 1 | A reservation is held |
| resv_addr | output | AW | Recorded reservation address |
| resv_size | output | 2 | Recorded reservation size code |

## Verification
Every result appears one clock edge after the request is accepted. The bench drives inputs on the falling edge. It lets exactly one rising edge pass and checks shortly after that edge. The reservation outputs and the status strobe therefore both belong to the request just issued. The bench drives the inputs back to no operation before the next edge, so each strobe can be checked to last only one cycle. An exhaustive sweep over a 4-bit address configuration pairs every recorded address and size with every store address, size and overflow value. The expected outcome is computed as equality of address and size.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'b00,
    OP_RESERVE = 2'b01,
    OP_COND    = 2'b10,
    OP_SPARE   = 2'b11
  } lrsc_op_e;

  localparam int SIZE_W   = 2;
  localparam int STATUS_W = 4;
  localparam logic [STATUS_W-1:0] STATUS_HIT = 4'b0010;
endpackage

// File: rtl/lrsc_resv_reg.sv
module lrsc_resv_reg
  import lrsc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              clear_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              valid_q,
  output logic [AW-1:0]     addr_q,
  output logic [SIZE_W-1:0] size_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
      size_q  <= size_i;
    end
  end

  p_clear_drops_r6: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !valid_q);
  p_set_records_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clear_i) |=> (valid_q && addr_q == $past(addr_i) && size_q == $past(size_i)));
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clear_i) |=> ($stable(valid_q) && $stable(addr_q) && $stable(size_q)));
endmodule

// File: rtl/lrsc_match.sv
module lrsc_match
  import lrsc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              valid_i,
  input  logic [AW-1:0]     resv_addr_i,
  input  logic [SIZE_W-1:0] resv_size_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              hit_o
);
  localparam int CW = AW + SIZE_W;

  logic [CW-1:0] lhs, rhs, bit_eq;

  assign lhs = {resv_size_i, resv_addr_i};
  assign rhs = {req_size_i, req_addr_i};

  for (genvar i = 0; i < CW; i++) begin : g_eq
    assign bit_eq[i] = ~(lhs[i] ^ rhs[i]);
  end

  assign hit_o = valid_i & (&bit_eq);
endmodule

// File: rtl/lrsc_status.sv
module lrsc_status
  import lrsc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cond_i,
  input  logic                hit_i,
  input  logic                ovf_i,
  output logic                done_q,
  output logic                ok_q,
  output logic [STATUS_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      status_q <= '0;
    end else if (cond_i) begin
      done_q   <= 1'b1;
      ok_q     <= hit_i;
      status_q <= (hit_i ? STATUS_HIT : '0) | {{(STATUS_W-1){1'b0}}, ovf_i};
    end else begin
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      status_q <= '0;
    end
  end

  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> (!ok_q && status_q == '0));
  p_done_follows_cond_r8: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> done_q);
  p_nibble_shape_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (status_q[3:2] == 2'b00 && status_q[1] == ok_q));
  p_ovf_passes_r5: assert property (@(posedge clk) disable iff (rst)
    cond_i |=> (status_q[0] == $past(ovf_i)));
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          req_op,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [AW-1:0]       req_addr,
  input  logic                sum_ovf,
  input  logic                inval,
  output logic                store_ok,
  output logic                status_done,
  output logic [STATUS_W-1:0] status,
  output logic                resv_valid,
  output logic [AW-1:0]       resv_addr,
  output logic [SIZE_W-1:0]   resv_size
);
  lrsc_op_e op;
  logic     is_reserve, is_cond, raw_hit, hit;

  assign op         = lrsc_op_e'(req_op);
  assign is_reserve = (op == OP_RESERVE);
  assign is_cond    = (op == OP_COND);

  lrsc_resv_reg #(.AW(AW)) u_resv (
    .clk     (clk),
    .rst     (rst),
    .set_i   (is_reserve),
    .clear_i (is_cond | inval),
    .addr_i  (req_addr),
    .size_i  (req_size),
    .valid_q (resv_valid),
    .addr_q  (resv_addr),
    .size_q  (resv_size)
  );

  lrsc_match #(.AW(AW)) u_match (
    .valid_i     (resv_valid),
    .resv_addr_i (resv_addr),
    .resv_size_i (resv_size),
    .req_addr_i  (req_addr),
    .req_size_i  (req_size),
    .hit_o       (raw_hit)
  );

  assign hit = raw_hit & ~inval;

  lrsc_status u_status (
    .clk      (clk),
    .rst      (rst),
    .cond_i   (is_cond),
    .hit_i    (hit),
    .ovf_i    (sum_ovf),
    .done_q   (status_done),
    .ok_q     (store_ok),
    .status_q (status)
  );

  p_no_resv_no_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (is_cond && !resv_valid) |=> !store_ok);
  p_inval_drops_r7: assert property (@(posedge clk) disable iff (rst)
    inval |=> !resv_valid);
  p_inval_fails_store_r7: assert property (@(posedge clk) disable iff (rst)
    (is_cond && inval) |=> !store_ok);
endmodule

// File: tb/lrsc_monitor_test.sv
`timescale 1ns/1ps
module lrsc_monitor_test;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    req_op;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic          sum_ovf;
  logic          inval;
  logic          store_ok, status_done, resv_valid;
  logic [3:0]    status;
  logic [AW-1:0] resv_addr;
  logic [1:0]    resv_size;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lrsc_monitor #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .sum_ovf(sum_ovf), .inval(inval),
    .store_ok(store_ok), .status_done(status_done), .status(status),
    .resv_valid(resv_valid), .resv_addr(resv_addr), .resv_size(resv_size)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, pass one rising edge, return idle inputs 1 ns later.
  task automatic issue(input logic [1:0] op, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic ov, input logic kl);
    @(negedge clk);
    req_op = op; req_size = sz; req_addr = a; sum_ovf = ov; inval = kl;
    @(posedge clk);
    #1;
    req_op = 2'b00; inval = 1'b0; sum_ovf = 1'b0;
  endtask

  task automatic expect_cond(input string req, input logic ok, input logic ov);
    check({req, " done"}, status_done, 1);
    check({req, " ok"}, store_ok, ok);
    check({req, " status"}, status, (ok ? 4'b0010 : 4'b0000) | {3'b000, ov});
    check({req, " resv cleared (R6)"}, resv_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req_op = 2'b00; req_size = 2'b00; req_addr = '0;
    sum_ovf = 1'b0; inval = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 resv_valid", resv_valid, 0);
    check("R1 done", status_done, 0);
    check("R1 ok", store_ok, 0);
    check("R1 status", status, 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 store without reservation fails
    issue(2'b10, 2'd2, 4'h3, 1'b1, 1'b0);
    expect_cond("R4 no reservation", 1'b0, 1'b1);
    // R8 strobe lasts one cycle
    @(posedge clk); #1;
    check("R8 done one cycle", status_done, 0);
    check("R8 ok zero when idle", store_ok, 0);
    check("R8 status zero when idle", status, 0);

    // R2/R4/R5/R6 exhaustive sweep
    for (int ra = 0; ra < 16; ra++)
      for (int rs = 0; rs < 4; rs++)
        for (int sa = 0; sa < 16; sa++)
          for (int ss = 0; ss < 4; ss++)
            for (int ov = 0; ov < 2; ov++) begin
              issue(2'b01, rs[1:0], ra[AW-1:0], 1'b0, 1'b0);
              check("R2 valid", resv_valid, 1);
              check("R2 addr", resv_addr, ra);
              check("R2 size", resv_size, rs);
              issue(2'b10, ss[1:0], sa[AW-1:0], ov[0], 1'b0);
              expect_cond("R4 R5 sweep", (ra == sa) && (rs == ss), ov[0]);
            end

    // R3 overwrite
    issue(2'b01, 2'd1, 4'h5, 1'b0, 1'b0);
    issue(2'b01, 2'd3, 4'hA, 1'b0, 1'b0);
    check("R3 addr overwritten", resv_addr, 4'hA);
    check("R3 size overwritten", resv_size, 3);
    issue(2'b10, 2'd1, 4'h5, 1'b0, 1'b0);
    expect_cond("R3 old reservation gone", 1'b0, 1'b0);

    // R6 failed store still drops; a retry at the right address then fails
    issue(2'b01, 2'd2, 4'h7, 1'b0, 1'b0);
    issue(2'b10, 2'd3, 4'h7, 1'b0, 1'b0);
    expect_cond("R6 size mismatch", 1'b0, 1'b0);
    issue(2'b10, 2'd2, 4'h7, 1'b0, 1'b0);
    expect_cond("R6 retry after drop", 1'b0, 1'b0);

    // R9 idle ops leave state alone
    issue(2'b01, 2'd0, 4'h9, 1'b0, 1'b0);
    issue(2'b00, 2'd3, 4'h1, 1'b1, 1'b0);
    check("R9 op00 no done", status_done, 0);
    issue(2'b11, 2'd3, 4'h1, 1'b1, 1'b0);
    check("R9 op11 no done", status_done, 0);
    check("R9 valid kept", resv_valid, 1);
    check("R9 addr kept", resv_addr, 4'h9);
    check("R9 size kept", resv_size, 0);
    issue(2'b10, 2'd0, 4'h9, 1'b1, 1'b0);
    expect_cond("R9 reservation survives idle ops", 1'b1, 1'b1);

    // R7 invalidate alone
    issue(2'b01, 2'd1, 4'h4, 1'b0, 1'b0);
    issue(2'b00, 2'd0, 4'h0, 1'b0, 1'b1);
    check("R7 inval clears", resv_valid, 0);
    issue(2'b10, 2'd1, 4'h4, 1'b0, 1'b0);
    expect_cond("R7 store after inval", 1'b0, 1'b0);
    // R7 inval with reserve
    issue(2'b01, 2'd2, 4'h6, 1'b0, 1'b1);
    check("R7 inval beats reserve", resv_valid, 0);
    // R7 inval with matching store
    issue(2'b01, 2'd2, 4'h6, 1'b0, 1'b0);
    issue(2'b10, 2'd2, 4'h6, 1'b1, 1'b1);
    expect_cond("R7 inval fails store", 1'b0, 1'b1);

    // R1 reset clears a held reservation
    issue(2'b01, 2'd3, 4'hF, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 reset drops reservation", resv_valid, 0);
    @(negedge clk); rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule